// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor's load/store port and a slower word-serial memory. Each line has one fixed home, picked from the address: the line number modulo the line count. A tag and a valid bit tell whether the home holds the requested line. A store that hits changes only the cached copy and marks the line dirty. Memory sees modified data only when a dirty line has to leave the cache to make room.

On a miss the processor is held by a stall output. A small sequencer first copies a dirty victim back to memory at that victim's own line address. It then fetches the requested line, so stores allocate as well. The stalled access completes once the new line is installed. The memory side is a request/acknowledge handshake. Each beat carries one word, its beat number, the line address and a write flag.

The processor keeps its address, strobe and write data steady while the stall output is high. The access completes in the first cycle in which the stall output is low. A store takes effect at the clock edge that ends that cycle. Read data is valid during that cycle.

Top module: `wb_dm_cache`

## Requirements
- R1: After reset every line is invalid. With no request pending, `cpu_stall` and `mem_req` are low, and the first access to any line is a miss.
- R2: An access hits only when the indexed line is valid and its stored tag equals address bits [31:10]. A hit completes in the cycle it is presented, with no stall and no memory request. A read hit returns the current word.
- R3: A write hit replaces only the addressed word in the cache, marks the line dirty and makes no memory transfer.
- R4: A miss whose indexed line is valid and dirty first performs 4 memory write beats. These carry the victim's stored tag and index as the line address and beats 0 to 3 in order, each with the victim's current word.
- R5: A miss whose indexed line is invalid or clean performs no write beats and goes straight to the 4 read beats of the requested line.
- R6: A write miss fetches the whole line from memory and then merges the write word into it. The line is dirty afterwards, so the merged value reaches memory on its eviction.
- R7: `cpu_stall` is high from the cycle a miss is seen until the cycle in which the access completes. That cycle follows the last refill beat.
- R8: A read miss that evicts a dirty line returns the word fetched from memory for the requested address, never the evicted data.
- R9: The address splits into tag [31:10], index [9:4], word [3:2] and an ignored byte field [1:0]. `mem_line` is the 28-bit line address and `mem_beat` the word number. A beat completes only on a cycle with `mem_ack` high, and request, flag, line and beat stay steady until then.
- R10: A freshly refilled line is clean. Evicting it without an intervening store causes no write beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request (wins if both strobes are high) |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when a read completes |
| cpu_stall | output | 1 | Access not yet complete; hold the request |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write beat (writeback), 0 = read beat (refill) |
| mem_line | output | 28 | Line address (tag and index) |
| mem_beat | output | 2 | Word number within the line |
| mem_wdata | output | 32 | Writeback word |
| mem_rdata | input | 32 | Refill word, sampled with `mem_ack` |
| mem_ack | input | 1 | Completes the current beat |

## Verification
Corruption of a valid bit or tag shows in the very first cycle of the next access to that index, as a stall level that disagrees with the expected hit or miss. A lost or spurious dirty bit shows one cycle after the miss is seen. The first memory beat is then a write where a read was due, or the reverse. A wrong word in the data array shows as soon as that word leaves the block. That happens either as read data in the completing cycle or as write data on a writeback beat, which can be many accesses later. The bench therefore keeps running a long mixed stream over a few colliding indices.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_CMP   = 2'd0,
    ST_WB    = 2'd1,
    ST_ALLOC = 2'd2,
    ST_DONE  = 2'd3
  } wbc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 64,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             set_dirty,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (set_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

  assign valid_o = valid_q[idx];
  assign dirty_o = dirty_q[idx];
  assign tag_o   = tag_q[idx];

  // R10: a refill leaves its line valid and clean
  assert_fill_clean_R10: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (valid_q[$past(idx)] && !dirty_q[$past(idx)]));

  // R3: a merged store leaves the line dirty
  assert_store_marks_dirty_R3: assert property (@(posedge clk) disable iff (rst)
    (set_dirty && !fill_en) |=> dirty_q[$past(idx)]);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 256,
  localparam int A_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [A_W-1:0]    waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [A_W-1:0]    raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import wbc_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              hit,
  input  logic              vic_dirty,
  input  logic              mem_ack,
  output wbc_state_e        state,
  output logic [BEAT_W-1:0] beat,
  output logic              fill_done
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  wbc_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_CMP: begin
        if (cpu_req && !hit) begin
          beat_d  = '0;
          state_d = vic_dirty ? ST_WB : ST_ALLOC;
        end
      end
      ST_WB: begin
        if (mem_ack) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST) begin
            beat_d  = '0;
            state_d = ST_ALLOC;
          end
        end
      end
      ST_ALLOC: begin
        if (mem_ack) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST) state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_CMP;
      default: state_d = ST_CMP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_CMP;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign state     = state_q;
  assign beat      = beat_q;
  assign fill_done = (state_q == ST_ALLOC) && mem_ack && (beat_q == LAST);

  // R4: the refill always follows a completed writeback, starting at beat 0
  assert_refill_after_wb_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WB && mem_ack && beat_q == LAST) |=> (state_q == ST_ALLOC && beat_q == '0));

  // R7: after the refill, one settle cycle, then the lookup again
  assert_done_returns_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |=> (state_q == ST_CMP));
endmodule

// File: rtl/wb_dm_cache.sv
module wb_dm_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 16,
  localparam int BYTE_W   = $clog2(WORD_W / 8),
  localparam int BEATS    = LINE_BYTES / (WORD_W / 8),
  localparam int BEAT_W   = $clog2(BEATS),
  localparam int OFFS_W   = $clog2(LINE_BYTES),
  localparam int IDX_W    = $clog2(LINES),
  localparam int TAG_W    = ADDR_W - OFFS_W - IDX_W,
  localparam int LINE_A_W = ADDR_W - OFFS_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  input  logic [WORD_W-1:0]   cpu_wdata,
  output logic [WORD_W-1:0]   cpu_rdata,
  output logic                cpu_stall,
  output logic                mem_req,
  output logic                mem_we,
  output logic [LINE_A_W-1:0] mem_line,
  output logic [BEAT_W-1:0]   mem_beat,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  logic                mem_ack
);
  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [BEAT_W-1:0] a_word;
  logic              unused_byte_bits;

  assign a_tag            = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_idx            = cpu_addr[OFFS_W +: IDX_W];
  assign a_word           = cpu_addr[BYTE_W +: BEAT_W];
  assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

  logic              cpu_req;
  logic              l_valid, l_dirty, hit;
  logic [TAG_W-1:0]  l_tag;
  wbc_state_e        state;
  logic [BEAT_W-1:0] beat;
  logic              fill_done;
  logic              store_hit, refill_we;
  logic [WORD_W-1:0] rd_word;

  assign cpu_req = cpu_rd | cpu_wr;
  assign hit     = l_valid && (l_tag == a_tag);

  dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .idx       (a_idx),
    .fill_en   (fill_done),
    .fill_tag  (a_tag),
    .set_dirty (store_hit),
    .valid_o   (l_valid),
    .dirty_o   (l_dirty),
    .tag_o     (l_tag)
  );

  dmc_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .hit       (hit),
    .vic_dirty (l_valid && l_dirty),
    .mem_ack   (mem_ack),
    .state     (state),
    .beat      (beat),
    .fill_done (fill_done)
  );

  assign store_hit = (state == ST_CMP) && cpu_wr && hit;
  assign refill_we = (state == ST_ALLOC) && mem_ack;

  dmc_data_store #(.WORD_W(WORD_W), .DEPTH(LINES * BEATS)) u_data (
    .clk   (clk),
    .we    (store_hit | refill_we),
    .waddr ({a_idx, (store_hit ? a_word : beat)}),
    .wdata (store_hit ? cpu_wdata : mem_rdata),
    .raddr ({a_idx, ((state == ST_WB) ? beat : a_word)}),
    .rdata (rd_word)
  );

  assign cpu_stall = (state != ST_CMP) || (cpu_req && !hit);
  assign cpu_rdata = rd_word;
  assign mem_req   = (state == ST_WB) || (state == ST_ALLOC);
  assign mem_we    = (state == ST_WB);
  assign mem_line  = (state == ST_WB) ? {l_tag, a_idx} : {a_tag, a_idx};
  assign mem_beat  = beat;
  assign mem_wdata = rd_word;

  // R2: a completing access never overlaps memory traffic
  assert_no_mem_on_hit_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_stall) |-> !mem_req);

  // R7: the stall only drops for an access whose line is present
  assert_release_on_hit_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_stall) |-> (l_valid && l_tag == a_tag));

  // R9: an unacknowledged beat holds its request fields
  assert_beat_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_beat) && $stable(mem_line)));
endmodule

// File: tb/tb_wb_dm_cache.sv
module tb_wb_dm_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we;
  logic [27:0] mem_line;
  logic [1:0]  mem_beat;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #2 clk = ~clk;

  wb_dm_cache dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_line(mem_line), .mem_beat(mem_beat),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit          we;
    logic [27:0] line;
    logic [1:0]  beat;
    logic [31:0] data;
  } txn_t;
  txn_t expq[$];

  logic [31:0] backing [int];  // memory as the bench models it
  logic [31:0] truth   [int];  // latest value seen by the processor
  bit          mv [64];
  bit          md [64];
  logic [21:0] mt [64];

  function automatic logic [31:0] seedv(int wa);
    return (wa * 32'h9E3779B1) ^ 32'h00005A5A;
  endfunction
  function automatic logic [31:0] memv(int wa);
    return backing.exists(wa) ? backing[wa] : seedv(wa);
  endfunction
  function automatic logic [31:0] truv(int wa);
    return truth.exists(wa) ? truth[wa] : seedv(wa);
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory responder: variable latency, one-cycle acknowledge pulses
  int lat = 1;
  int lat_seed = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R2 unexpected memory request", {31'd0, mem_we}, 32'd0);
        end else if (lat > 0) begin
          lat--;
        end else begin
          txn_t t;
          int   wa;
          t = expq.pop_front();
          chk(mem_we == t.we, t.we ? "R4 writeback beat expected" : "R5 refill beat expected",
              {31'd0, mem_we}, {31'd0, t.we});
          chk(mem_line == t.line && mem_beat == t.beat, "R9 beat line/number",
              {2'b00, mem_line, mem_beat}, {2'b00, t.line, t.beat});
          wa = int'({mem_line, mem_beat});
          if (t.we) begin
            chk(mem_wdata == t.data, "R4 writeback word", mem_wdata, t.data);
            backing[wa] = mem_wdata;
          end else begin
            mem_rdata = memv(wa);
          end
          mem_ack = 1'b1;
          lat_seed++;
          lat = lat_seed % 3;
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [21:0] tg, input logic [5:0] ix,
                        input logic [1:0] wd, input logic [31:0] d, input string lbl);
    logic [31:0] a;
    int          wa;
    bit          hm;
    bit          dv;
    int          g;
    a  = {tg, ix, wd, 2'b00};
    wa = int'(a[31:2]);
    hm = mv[ix] && (mt[ix] == tg);
    dv = mv[ix] && md[ix];
    @(negedge clk);
    cpu_addr = a; cpu_rd = !wr; cpu_wr = wr; cpu_wdata = d;
    #1;
    chk(cpu_stall == !hm, hm ? "R2 hit presents no stall" : "R7 miss raises stall",
        {31'd0, cpu_stall}, {31'd0, !hm});
    if (!hm) begin
      if (dv) begin
        for (int b = 0; b < 4; b++) begin
          expq.push_back('{1'b1, {mt[ix], ix}, 2'(b), truv(int'({mt[ix], ix, 2'(b)}))});
        end
      end
      for (int b = 0; b < 4; b++) expq.push_back('{1'b0, {tg, ix}, 2'(b), 32'd0});
      mv[ix] = 1'b1; mt[ix] = tg; md[ix] = 1'b0;
    end else begin
      chk(!mem_req, "R3 hit makes no memory transfer", {31'd0, mem_req}, 32'd0);
    end
    g = 0;
    while (cpu_stall && g < 1000) begin
      @(negedge clk); #1; g++;
    end
    chk(expq.size() == 0, "R9 all beats acknowledged before completion", expq.size(), 32'd0);
    if (!wr) begin
      chk(cpu_rdata == truv(wa), {lbl, " read data"}, cpu_rdata, truv(wa));
    end else begin
      truth[wa] = d;
      md[ix] = 1'b1;
    end
    chk(!mem_req, {lbl, " no request at completion"}, {31'd0, mem_req}, 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mv[i] = 0; md[i] = 0; mt[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!cpu_stall && !mem_req, "R1 idle after reset", {30'd0, cpu_stall, mem_req}, 32'd0);

    access(0, 22'd1, 6'd5, 2'd0, 32'd0, "R1 first access misses, R5 clean refill");
    access(0, 22'd1, 6'd5, 2'd3, 32'd0, "R2 read hit");
    access(1, 22'd1, 6'd5, 2'd2, 32'hCAFE0001, "R3 write hit");
    access(0, 22'd1, 6'd5, 2'd2, 32'd0, "R3 read back stored word");
    access(0, 22'd2, 6'd5, 2'd1, 32'd0, "R8 read miss evicting dirty line");
    access(0, 22'd1, 6'd5, 2'd2, 32'd0, "R4 written-back word returns, R10 no writeback");
    access(1, 22'd3, 6'd9, 2'd0, 32'h12345678, "R6 write miss allocates");
    access(0, 22'd3, 6'd9, 2'd0, 32'd0, "R6 merged word");
    access(0, 22'd3, 6'd9, 2'd1, 32'd0, "R6 neighbour from refill");
    access(0, 22'd4, 6'd9, 2'd0, 32'd0, "R6 allocated line is dirty");
    access(0, 22'd3, 6'd9, 2'd0, 32'd0, "R4 merged value survived eviction");
    access(0, 22'd7, 6'd12, 2'd0, 32'd0, "R10 refill");
    access(0, 22'd8, 6'd12, 2'd3, 32'd0, "R10 clean eviction");
    access(1, 22'h3FFFFF, 6'd63, 2'd3, 32'hA5A5F00F, "R9 top index, top tag");
    access(1, 22'h3FFFFF, 6'd0, 2'd0, 32'h0F0F0F0F, "R9 index zero");
    access(0, 22'd0, 6'd0, 2'd0, 32'd0, "R8 index zero dirty eviction");
    access(0, 22'h3FFFFF, 6'd63, 2'd3, 32'd0, "R9 top index read back");
    access(1, 22'd0, 6'd63, 2'd1, 32'h00C0FFEE, "R6 write miss over dirty line");

    for (int n = 0; n < 400; n++) begin
      logic [5:0] ix;
      logic [1:0] sel;
      sel = 2'($urandom_range(0, 3));
      ix  = (sel == 0) ? 6'd0 : (sel == 1) ? 6'd1 : (sel == 2) ? 6'd63 : 6'd5;
      access(1'($urandom_range(0, 1)), 22'($urandom_range(0, 3)), ix,
             2'($urandom_range(0, 3)), $urandom, "R2 mixed stream");
    end

    @(negedge clk); cpu_rd = 1'b0; cpu_wr = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!cpu_stall && !mem_req, "R1 idle at end", {30'd0, cpu_stall, mem_req}, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule